// File: doc/BRIEF.md
# General-Purpose I/O Pin Bank with Peripheral Override

A bank of `NPINS` general-purpose I/O pins. Each pin holds a direction bit and a port bit, both loaded by software write strobes, and presents a synchronized copy of its pad level for software to read. A single global input disables every register-controlled pull-up at once.

Any peripheral that shares a pin may take over the pin, one signal at a time. It does this through an enable/value pair for each of these signals: pull-up, output enable, output value and digital input enable. It can also pulse a toggle strobe that flips the stored port bit. Each pair is independent: a peripheral can drive the pad value while software still sets the direction. The block drives the pad output enable, the pad output value and the pull-up enable. For peripherals it gives the gated digital input before any synchronizer. For the register read path it gives a copy of that input taken through a flip-flop synchronizer.

Top module: `pinbank_ovr`

## Requirements
- R1: With `pu_ovr_en[i]`=0, `pull_en[i]` is 1 exactly when {`dir_q[i]`, `port_q[i]`, `pud_all`} is 3'b010.
- R2: With `pu_ovr_en[i]`=1, `pull_en[i]` equals `pu_ovr_val[i]`, whatever the direction bit, port bit and `pud_all`.
- R3: `pad_oe[i]` equals `dd_ovr_val[i]` when `dd_ovr_en[i]`=1, else `dir_q[i]`.
- R4: When `pad_oe[i]`=1, `pad_out[i]` equals `pv_ovr_val[i]` if `pv_ovr_en[i]`=1, else `port_q[i]`. When `pad_oe[i]`=0, `pad_out[i]` is 0.
- R5: Each clock edge at which `tgl_ovr[i]`=1 and `wr_port`=0 inverts `port_q[i]`. Holding the strobe high for N cycles inverts the bit N times.
- R6: A clock edge with `wr_port`=1 loads `port_q` from `wdata` and ignores `tgl_ovr` in that cycle.
- R7: The digital input enable of pin i is `die_ovr_val[i]` when `die_ovr_en[i]`=1, else the inverse of `sleep_mode`. `raw_din[i]` is `pad_in[i]` AND that enable, with no register in the path.
- R8: `sync_din` equals `raw_din` as it was two clock edges earlier.
- R9: Reset (`rst_n`=0) clears `dir_q`, `port_q` and `sync_din`, so every pin is an undriven input with no pull-up while no override is active.
- R10: A clock edge with `wr_dir`=1 loads `dir_q` from `wdata`. Otherwise `dir_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_dir | input | 1 | Load direction bits from `wdata` |
| wr_port | input | 1 | Load port bits from `wdata` |
| wdata | input | NPINS | Software write data |
| pud_all | input | 1 | Global pull-up disable |
| sleep_mode | input | 1 | Device sleeping: input buffers off unless overridden |
| pu_ovr_en | input | NPINS | Pull-up override enable |
| pu_ovr_val | input | NPINS | Pull-up override value |
| dd_ovr_en | input | NPINS | Output-enable override enable |
| dd_ovr_val | input | NPINS | Output-enable override value |
| pv_ovr_en | input | NPINS | Output-value override enable |
| pv_ovr_val | input | NPINS | Output-value override value |
| tgl_ovr | input | NPINS | Port bit toggle strobe |
| die_ovr_en | input | NPINS | Input-enable override enable |
| die_ovr_val | input | NPINS | Input-enable override value |
| pad_in | input | NPINS | Level seen at the pad input buffer |
| pad_oe | output | NPINS | Pad output driver enable |
| pad_out | output | NPINS | Pad output value |
| pull_en | output | NPINS | Pad pull-up enable |
| raw_din | output | NPINS | Gated, unsynchronized input for peripherals |
| sync_din | output | NPINS | Synchronized input for the read path |
| dir_q | output | NPINS | Direction register state |
| port_q | output | NPINS | Port register state |

## Verification
The only state in the block is the direction and port registers and the synchronizer chain. A wrong port bit shows at `port_q` one edge after the stimulus that caused it. If the pin is an input, it also shows at `pull_en` in the same cycle. If the pin drives, it shows at `pad_out`. A wrong direction bit shows at once at `pad_oe` while the direction override is off. A synchronizer fault shows as a `sync_din` mismatch exactly two edges after the pad change. The bench compares every output in every cycle, so each of these faults is caught within a cycle or two of its cause.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_PINS        = 64;

   // register-driven pull-up: input pin, port bit high, not globally disabled
   function automatic logic pull_from_regs(input logic dir_b, input logic prt_b,
                                           input logic pud_b);
      return ({dir_b, prt_b, pud_b} == 3'b010);
   endfunction
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_port,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] tgl,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] port_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else begin
         if (wr_dir)
            dir_q <= wdata;
         if (wr_port)
            port_q <= wdata;
         else
            port_q <= port_q ^ tgl;
      end
   end

   p_toggle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_port |=> (port_q == $past(port_q ^ tgl)));
   p_write_wins_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_port |=> (port_q == $past(wdata)));
   p_dir_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/pinbank_pinmux.sv
module pinbank_pinmux
   import pinbank_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic             pud_all,
   input  logic             sleep_mode,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] port_q,
   input  logic [NPINS-1:0] pu_ovr_en,
   input  logic [NPINS-1:0] pu_ovr_val,
   input  logic [NPINS-1:0] dd_ovr_en,
   input  logic [NPINS-1:0] dd_ovr_val,
   input  logic [NPINS-1:0] pv_ovr_en,
   input  logic [NPINS-1:0] pv_ovr_val,
   input  logic [NPINS-1:0] die_ovr_en,
   input  logic [NPINS-1:0] die_ovr_val,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pull_en,
   output logic [NPINS-1:0] raw_din
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic oe_w, val_w, die_w;
      always_comb begin
         oe_w  = dd_ovr_en[i]  ? dd_ovr_val[i]  : dir_q[i];
         val_w = pv_ovr_en[i]  ? pv_ovr_val[i]  : port_q[i];
         die_w = die_ovr_en[i] ? die_ovr_val[i] : ~sleep_mode;
      end
      assign pad_oe[i]  = oe_w;
      assign pad_out[i] = oe_w & val_w;
      assign pull_en[i] = pu_ovr_en[i] ? pu_ovr_val[i]
                                       : pull_from_regs(dir_q[i], port_q[i], pud_all);
      assign raw_din[i] = pad_in[i] & die_w;
   end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync
   import pinbank_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("pinbank_sync: STAGES below minimum");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= din;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk2
      logic [1:0] seen;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             seen <= '0;
         else if (seen != 2'd2)  seen <= seen + 2'd1;
      end
      p_sync_delay_r8 : assert property (@(posedge clk) disable iff (!rst_n)
         (seen == 2'd2) |-> (dout == $past(din, 2)));
   end
endmodule

// File: rtl/pinbank_ovr.sv
module pinbank_ovr
   import pinbank_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_port,
   input  logic [NPINS-1:0] wdata,
   input  logic             pud_all,
   input  logic             sleep_mode,
   input  logic [NPINS-1:0] pu_ovr_en,
   input  logic [NPINS-1:0] pu_ovr_val,
   input  logic [NPINS-1:0] dd_ovr_en,
   input  logic [NPINS-1:0] dd_ovr_val,
   input  logic [NPINS-1:0] pv_ovr_en,
   input  logic [NPINS-1:0] pv_ovr_val,
   input  logic [NPINS-1:0] tgl_ovr,
   input  logic [NPINS-1:0] die_ovr_en,
   input  logic [NPINS-1:0] die_ovr_val,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pull_en,
   output logic [NPINS-1:0] raw_din,
   output logic [NPINS-1:0] sync_din,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] port_q
);
   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("pinbank_ovr: NPINS out of range");
   end

   pinbank_regs #(.NPINS(NPINS)) u_regs (
      .clk, .rst_n, .wr_dir, .wr_port, .wdata,
      .tgl(tgl_ovr), .dir_q, .port_q
   );

   pinbank_pinmux #(.NPINS(NPINS)) u_mux (
      .pud_all, .sleep_mode, .dir_q, .port_q,
      .pu_ovr_en, .pu_ovr_val, .dd_ovr_en, .dd_ovr_val,
      .pv_ovr_en, .pv_ovr_val, .die_ovr_en, .die_ovr_val,
      .pad_in, .pad_oe, .pad_out, .pull_en, .raw_din
   );

   pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .din(raw_din), .dout(sync_din)
   );

   p_idle_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0));
   p_sleep_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      sleep_mode |-> ((raw_din & ~die_ovr_en) == '0));
   p_reset_clear_r9 : assert property (@(posedge clk)
      !rst_n |=> (dir_q == '0 && port_q == '0 && sync_din == '0));
endmodule

// File: tb/sim_pinbank_ovr.sv
module sim_pinbank_ovr;
   localparam int NP = 8;
   logic clk = 0, rst_n = 0;
   logic wr_dir, wr_port, pud_all, sleep_mode;
   logic [NP-1:0] wdata, pu_en, pu_val, dd_en, dd_val, pv_en, pv_val, tgl, die_en, die_val, pad_in;
   logic [NP-1:0] pad_oe, pad_out, pull_en, raw_din, sync_din, dir_q, port_q;
   logic [NP-1:0] dir_m, port_m, s1_m, s2_m;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   pinbank_ovr #(.NPINS(NP), .SYNC_STAGES(2)) u0 (
      .clk, .rst_n, .wr_dir, .wr_port, .wdata, .pud_all, .sleep_mode,
      .pu_ovr_en(pu_en), .pu_ovr_val(pu_val), .dd_ovr_en(dd_en), .dd_ovr_val(dd_val),
      .pv_ovr_en(pv_en), .pv_ovr_val(pv_val), .tgl_ovr(tgl),
      .die_ovr_en(die_en), .die_ovr_val(die_val), .pad_in,
      .pad_oe, .pad_out, .pull_en, .raw_din, .sync_din, .dir_q, .port_q
   );

   function automatic logic [NP-1:0] f_pull();
      return (pu_en & pu_val) | (~pu_en & ~dir_m & port_m & {NP{~pud_all}});
   endfunction
   function automatic logic [NP-1:0] f_oe();
      return (dd_en & dd_val) | (~dd_en & dir_m);
   endfunction
   function automatic logic [NP-1:0] f_out();
      return f_oe() & ((pv_en & pv_val) | (~pv_en & port_m));
   endfunction
   function automatic logic [NP-1:0] f_raw();
      return pad_in & ((die_en & die_val) | (~die_en & {NP{~sleep_mode}}));
   endfunction

   task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%b exp=%b", tag, got, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_dir = 0; wr_port = 0; wdata = '0; pud_all = 0; sleep_mode = 0;
      pu_en = '0; pu_val = '0; dd_en = '0; dd_val = '0; pv_en = '0; pv_val = '0;
      tgl = '0; die_en = '0; die_val = '0; pad_in = '0;
   endtask

   // checks all outputs in the current cycle, then steps the model over one edge
   task automatic check_and_step();
      #1;
      check("R1/R2 pull_en", pull_en, f_pull());
      check("R3 pad_oe", pad_oe, f_oe());
      check("R4 pad_out", pad_out, f_out());
      check("R7 raw_din", raw_din, f_raw());
      check("R8 sync_din", sync_din, s2_m);
      check("R10 dir_q", dir_q, dir_m);
      check("R5/R6 port_q", port_q, port_m);
      s2_m = s1_m; s1_m = f_raw();
      if (wr_dir) dir_m = wdata;
      port_m = wr_port ? wdata : (port_m ^ tgl);
      @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      dir_m = '0; port_m = '0; s1_m = '0; s2_m = '0;
      pad_in = '1;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 dir_q reset", dir_q, '0);
      check("R9 port_q reset", port_q, '0);
      check("R9 sync_din reset", sync_din, '0);
      check("R9 pull_en reset", pull_en, '0);
      check("R9 pad_oe reset", pad_oe, '0);
      rst_n = 1;
      pad_in = '0;
      @(negedge clk);

      // R5: toggle held high three cycles inverts three times
      tgl = 8'hA5;
      repeat (3) check_and_step();
      tgl = '0;
      check_and_step();
      check("R5 triple toggle", port_q, 8'hA5);

      // R6: write and toggle in the same cycle, write wins
      wr_port = 1; wdata = 8'h3C; tgl = 8'hFF;
      check_and_step();
      wr_port = 0; tgl = '0;
      check_and_step();
      check("R6 write over toggle", port_q, 8'h3C);

      // R1: global disable kills register pull-up; override wins (R2)
      pud_all = 1; pu_en = 8'h0F; pu_val = 8'h05;
      check_and_step();
      check("R2 override under pud", pull_en, 8'h05);
      idle_inputs();

      // R7: sleep gates input unless overridden
      sleep_mode = 1; pad_in = '1; die_en = 8'hF0; die_val = 8'h30;
      check_and_step();
      check("R7 sleep gating", raw_din, 8'h30);
      idle_inputs();
      check_and_step();

      // random sweep over all per-pin combinations (R1..R8, R10)
      for (int c = 0; c < 4000; c++) begin
         wr_dir  = ($urandom % 4) == 0;
         wr_port = ($urandom % 4) == 0;
         wdata   = NP'($urandom);
         pud_all = ($urandom % 3) == 0;
         sleep_mode = ($urandom % 3) == 0;
         pu_en  = NP'($urandom); pu_val = NP'($urandom);
         dd_en  = NP'($urandom); dd_val = NP'($urandom);
         pv_en  = NP'($urandom); pv_val = NP'($urandom);
         tgl    = NP'($urandom & $urandom);
         die_en = NP'($urandom); die_val = NP'($urandom);
         pad_in = NP'($urandom);
         check_and_step();
      end

      // R9: reset mid-run clears state again
      rst_n = 0;
      dir_m = '0; port_m = '0; s1_m = '0; s2_m = '0;
      @(negedge clk);
      check("R9 dir_q re-reset", dir_q, '0);
      check("R9 port_q re-reset", port_q, '0);
      check("R9 sync re-reset", sync_din, '0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule